// File: doc/BRIEF.md
# Debug-to-CPU Word Mailbox

This block moves single 32-bit words between an external debugger and the on-chip CPU, one word in each direction. Each side has its own simple register port with select, write strobe, 2-bit word address, write data and registered read data. The downlink direction runs from the debugger to the CPU. The debugger deposits a word and some generic flag bits, and the CPU picks them up. The uplink direction runs from the CPU to the debugger. The CPU deposits a word and a few generic flag bits, and the debugger picks them up.

Each direction holds a full/empty bit. The producer's data write sets it, and the consumer's read of the data word clears it as a side effect. The debugger polls these bits to decide when to post a new downlink word or collect an uplink word. Two one-cycle event pulses can feed an interrupt aggregator. One marks a fresh downlink word. The other marks that the debugger has collected the uplink word.

Both ports see the same four-word map. Word 0 is the downlink data. Word 1 is the downlink control: the full bit at bit 0 and the debugger flags above it. Word 2 is the uplink data. Word 3 is the uplink control: the full bit at bit 0, the CPU flags in bits 7:1, and zero above them.

Top module: `dbg_mailbox`

## Requirements
- R1: The downlink data word (address 0) resets to zero. It takes the write data of a debugger write to address 0. A CPU write to address 0 leaves it unchanged.
- R2: Downlink full, which is bit 0 of address 1, becomes 1 after a debugger write to address 0. It becomes 0 after a CPU read of address 0. Reading address 1 returns it.
- R3: Bits 31:1 of address 1 hold the downlink flags. They take bits 31:1 of a debugger write to address 1. A CPU write to address 1 does not change them, and neither write changes the full bit.
- R4: The uplink data word (address 2) resets to zero. It takes the write data of a CPU write to address 2. A debugger write to address 2 leaves it unchanged.
- R5: Uplink full, which is bit 0 of address 3, becomes 1 after a CPU write to address 2. It becomes 0 after a debugger read of address 2. Writes to address 3 do not change it.
- R6: Bits 7:1 of address 3 hold the uplink flags. They take bits 7:1 of a CPU write to address 3. Bits 31:8 of address 3 always read 0. A debugger write to address 3 changes nothing.
- R7: `tx_evt` is high for exactly the one cycle after each debugger write to address 0. At every other time it is low.
- R8: `rx_evt` is high for exactly the one cycle after each debugger read of address 2. At every other time it is low.
- R9: A producer write to a data word whose full bit is already 1 replaces the stored word, and the full bit stays 1.
- R10: A producer write and a consumer read of the same data word can fall in the same cycle. In that case the reader gets the old word and the full bit ends at 1.
- R11: Read data appears on a port's read data output the cycle after that port's read request (select high, write low). It holds until that port's next read.
- R12: While reset is high, every output and every stored word and bit returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | CPU port access strobe |
| cpu_wr | input | 1 | CPU port write (1) or read (0) |
| cpu_addr | input | 2 | CPU port word address |
| cpu_wdata | input | 32 | CPU port write data |
| cpu_rdata | output | 32 | CPU port registered read data |
| dbg_sel | input | 1 | Debugger port access strobe |
| dbg_wr | input | 1 | Debugger port write (1) or read (0) |
| dbg_addr | input | 2 | Debugger port word address |
| dbg_wdata | input | 32 | Debugger port write data |
| dbg_rdata | output | 32 | Debugger port registered read data |
| tx_evt | output | 1 | One-cycle pulse: a new downlink word was posted |
| rx_evt | output | 1 | One-cycle pulse: the uplink word was collected |

## Verification
The bench builds the block with the default 32-bit data width and 7 uplink flag bits. With these values an all-ones write reaches every downlink flag bit and shows the exact boundary where uplink flag bits end and the reserved zero bits begin. The directed phases cover overwrite while full and same-cycle produce/consume collisions on both directions. A random phase then drives concurrent traffic on both ports against the cycle model.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MBOX_AW = 2;

  typedef enum logic [MBOX_AW-1:0] {
    REG_DN_DATA = 2'd0,
    REG_DN_CTRL = 2'd1,
    REG_UP_DATA = 2'd2,
    REG_UP_CTRL = 2'd3
  } mbox_reg_e;
endpackage

// File: rtl/mbox_slot.sv
// Single-word hand-off: data, generic flags, full bit and one event pulse.
module mbox_slot #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned FLAG_W      = 31,
  parameter bit          EVT_ON_TAKE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              put_data,
  input  logic [DATA_W-1:0] put_word,
  input  logic              put_flags,
  input  logic [FLAG_W-1:0] flag_word,
  input  logic              take,
  output logic [DATA_W-1:0] data_q,
  output logic [FLAG_W-1:0] flags_q,
  output logic              full_q,
  output logic              evt_q
);
  logic evt_src;

  generate
    if (EVT_ON_TAKE) begin : g_evt_take
      assign evt_src = take;
    end else begin : g_evt_put
      assign evt_src = put_data;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      flags_q <= '0;
      full_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      if (put_data)  data_q  <= put_word;
      if (put_flags) flags_q <= flag_word;
      // a write in the same cycle as a read wins: the word is fresh
      if (put_data)  full_q  <= 1'b1;
      else if (take) full_q  <= 1'b0;
      evt_q <= evt_src;
    end
  end
endmodule

// File: rtl/mbox_rd_port.sv
// Registered read mux for one access port.
module mbox_rd_port
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               wr,
  input  logic [MBOX_AW-1:0] addr,
  input  logic [DATA_W-1:0]  dn_data,
  input  logic [DATA_W-1:0]  dn_ctrl,
  input  logic [DATA_W-1:0]  up_data,
  input  logic [DATA_W-1:0]  up_ctrl,
  output logic [DATA_W-1:0]  rdata_q
);
  logic [DATA_W-1:0] mux_w;

  always_comb begin
    unique case (mbox_reg_e'(addr))
      REG_DN_DATA: mux_w = dn_data;
      REG_DN_CTRL: mux_w = dn_ctrl;
      REG_UP_DATA: mux_w = up_data;
      REG_UP_CTRL: mux_w = up_ctrl;
      default:     mux_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            rdata_q <= '0;
    else if (sel && !wr) rdata_q <= mux_w;
  end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned UP_FLAG_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_sel,
  input  logic               cpu_wr,
  input  logic [MBOX_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  input  logic               dbg_sel,
  input  logic               dbg_wr,
  input  logic [MBOX_AW-1:0] dbg_addr,
  input  logic [DATA_W-1:0]  dbg_wdata,
  output logic [DATA_W-1:0]  dbg_rdata,
  output logic               tx_evt,
  output logic               rx_evt
);
  localparam int unsigned DN_FLAG_W = DATA_W - 1;
  localparam int unsigned UP_PAD_W  = DATA_W - UP_FLAG_W - 1;

  // access decode
  logic cpu_wr_e, cpu_rd_e, dbg_wr_e, dbg_rd_e;
  assign cpu_wr_e = cpu_sel &&  cpu_wr;
  assign cpu_rd_e = cpu_sel && !cpu_wr;
  assign dbg_wr_e = dbg_sel &&  dbg_wr;
  assign dbg_rd_e = dbg_sel && !dbg_wr;

  logic dn_put, dn_put_flags, dn_take;
  logic up_put, up_put_flags, up_take;
  assign dn_put       = dbg_wr_e && (mbox_reg_e'(dbg_addr) == REG_DN_DATA);
  assign dn_put_flags = dbg_wr_e && (mbox_reg_e'(dbg_addr) == REG_DN_CTRL);
  assign dn_take      = cpu_rd_e && (mbox_reg_e'(cpu_addr) == REG_DN_DATA);
  assign up_put       = cpu_wr_e && (mbox_reg_e'(cpu_addr) == REG_UP_DATA);
  assign up_put_flags = cpu_wr_e && (mbox_reg_e'(cpu_addr) == REG_UP_CTRL);
  assign up_take      = dbg_rd_e && (mbox_reg_e'(dbg_addr) == REG_UP_DATA);

  logic [DATA_W-1:0]    dn_data, up_data;
  logic [DN_FLAG_W-1:0] dn_flags;
  logic [UP_FLAG_W-1:0] up_flags;
  logic                 dn_full, up_full;

  mbox_slot #(.DATA_W(DATA_W), .FLAG_W(DN_FLAG_W), .EVT_ON_TAKE(1'b0)) dn_slot_i (
    .clk       (clk),
    .rst       (rst),
    .put_data  (dn_put),
    .put_word  (dbg_wdata),
    .put_flags (dn_put_flags),
    .flag_word (dbg_wdata[DATA_W-1:1]),
    .take      (dn_take),
    .data_q    (dn_data),
    .flags_q   (dn_flags),
    .full_q    (dn_full),
    .evt_q     (tx_evt)
  );

  mbox_slot #(.DATA_W(DATA_W), .FLAG_W(UP_FLAG_W), .EVT_ON_TAKE(1'b1)) up_slot_i (
    .clk       (clk),
    .rst       (rst),
    .put_data  (up_put),
    .put_word  (cpu_wdata),
    .put_flags (up_put_flags),
    .flag_word (cpu_wdata[UP_FLAG_W:1]),
    .take      (up_take),
    .data_q    (up_data),
    .flags_q   (up_flags),
    .full_q    (up_full),
    .evt_q     (rx_evt)
  );

  logic [DATA_W-1:0] dn_ctrl, up_ctrl;
  assign dn_ctrl = {dn_flags, dn_full};
  assign up_ctrl = {{UP_PAD_W{1'b0}}, up_flags, up_full};

  mbox_rd_port #(.DATA_W(DATA_W)) cpu_rd_i (
    .clk     (clk),
    .rst     (rst),
    .sel     (cpu_sel),
    .wr      (cpu_wr),
    .addr    (cpu_addr),
    .dn_data (dn_data),
    .dn_ctrl (dn_ctrl),
    .up_data (up_data),
    .up_ctrl (up_ctrl),
    .rdata_q (cpu_rdata)
  );

  mbox_rd_port #(.DATA_W(DATA_W)) dbg_rd_i (
    .clk     (clk),
    .rst     (rst),
    .sel     (dbg_sel),
    .wr      (dbg_wr),
    .addr    (dbg_addr),
    .dn_data (dn_data),
    .dn_ctrl (dn_ctrl),
    .up_data (up_data),
    .up_ctrl (up_ctrl),
    .rdata_q (dbg_rdata)
  );
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_sel,
  input logic              cpu_wr,
  input logic [1:0]        cpu_addr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              dbg_sel,
  input logic              dbg_wr,
  input logic [1:0]        dbg_addr,
  input logic [DATA_W-1:0] dbg_wdata,
  input logic              tx_evt,
  input logic              rx_evt,
  input logic              dn_full,
  input logic              up_full,
  input logic [DATA_W-1:0] dn_data,
  input logic [DATA_W-1:0] up_data
);
  logic c_dn_wr, c_dn_rd, c_up_wr, c_up_rd;
  assign c_dn_wr = dbg_sel &&  dbg_wr && (dbg_addr == 2'd0);
  assign c_dn_rd = cpu_sel && !cpu_wr && (cpu_addr == 2'd0);
  assign c_up_wr = cpu_sel &&  cpu_wr && (cpu_addr == 2'd2);
  assign c_up_rd = dbg_sel && !dbg_wr && (dbg_addr == 2'd2);

  p_dn_ro_r1: assert property (@(posedge clk) disable iff (rst)
    !c_dn_wr |=> $stable(dn_data));
  p_dn_set_r2: assert property (@(posedge clk) disable iff (rst)
    c_dn_wr |=> dn_full);
  p_dn_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (c_dn_rd && !c_dn_wr) |=> !dn_full);
  p_up_ro_r4: assert property (@(posedge clk) disable iff (rst)
    !c_up_wr |=> $stable(up_data));
  p_up_set_r5: assert property (@(posedge clk) disable iff (rst)
    c_up_wr |=> up_full);
  p_up_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (c_up_rd && !c_up_wr) |=> !up_full);
  p_tx_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    c_dn_wr |=> tx_evt);
  p_tx_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !c_dn_wr |=> !tx_evt);
  p_rx_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    c_up_rd |=> rx_evt);
  p_rx_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !c_up_rd |=> !rx_evt);
  p_overwrite_r9: assert property (@(posedge clk) disable iff (rst)
    (dn_full && c_dn_wr) |=> (dn_full && dn_data == $past(dbg_wdata)));
  p_collide_r10: assert property (@(posedge clk) disable iff (rst)
    (c_up_wr && c_up_rd) |=> up_full);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(cpu_sel && !cpu_wr) |=> $stable(cpu_rdata));
endmodule

bind dbg_mailbox mbox_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cpu_sel   (cpu_sel),
  .cpu_wr    (cpu_wr),
  .cpu_addr  (cpu_addr),
  .cpu_rdata (cpu_rdata),
  .dbg_sel   (dbg_sel),
  .dbg_wr    (dbg_wr),
  .dbg_addr  (dbg_addr),
  .dbg_wdata (dbg_wdata),
  .tx_evt    (tx_evt),
  .rx_evt    (rx_evt),
  .dn_full   (dn_full),
  .up_full   (up_full),
  .dn_data   (dn_data),
  .up_data   (up_data)
);

// File: tb/dbg_mailbox_tb_top.sv
module dbg_mailbox_tb_top;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic          cpu_sel, cpu_wr, dbg_sel, dbg_wr;
  logic [1:0]    cpu_addr, dbg_addr;
  logic [DW-1:0] cpu_wdata, dbg_wdata, cpu_rdata, dbg_rdata;
  logic          tx_evt, rx_evt;

  dbg_mailbox #(.DATA_W(DW), .UP_FLAG_W(7)) dut_i (
    .clk(clk), .rst(rst),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dbg_sel(dbg_sel), .dbg_wr(dbg_wr), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .tx_evt(tx_evt), .rx_evt(rx_evt)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_dn_data, m_up_data, m_cpu_rd, m_dbg_rd;
  logic [30:0] m_dn_flags;
  logic [6:0]  m_up_flags;
  bit          m_dn_full, m_up_full, m_tx, m_rx;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0:    return m_dn_data;
      2'd1:    return {m_dn_flags, m_dn_full};
      2'd2:    return m_up_data;
      default: return {24'h0, m_up_flags, m_up_full};
    endcase
  endfunction

  task automatic model_reset();
    m_dn_data = 0; m_up_data = 0; m_cpu_rd = 0; m_dbg_rd = 0;
    m_dn_flags = 0; m_up_flags = 0;
    m_dn_full = 0; m_up_full = 0; m_tx = 0; m_rx = 0;
  endtask

  // one clock: drive at negedge, predict, compare at the next negedge
  task automatic step(string tag, bit cs, bit cw, logic [1:0] ca, logic [31:0] cd,
                      bit ds, bit dw, logic [1:0] da, logic [31:0] dd);
    logic [31:0] n_dn_data, n_up_data, n_cpu_rd, n_dbg_rd;
    logic [30:0] n_dn_flags;
    logic [6:0]  n_up_flags;
    bit n_dn_full, n_up_full, c_rd, d_rd;
    cpu_sel = cs; cpu_wr = cw; cpu_addr = ca; cpu_wdata = cd;
    dbg_sel = ds; dbg_wr = dw; dbg_addr = da; dbg_wdata = dd;
    c_rd = cs && !cw;
    d_rd = ds && !dw;
    n_dn_data = m_dn_data; n_up_data = m_up_data;
    n_dn_flags = m_dn_flags; n_up_flags = m_up_flags;
    n_dn_full = m_dn_full; n_up_full = m_up_full;
    n_cpu_rd = c_rd ? m_read(ca) : m_cpu_rd;
    n_dbg_rd = d_rd ? m_read(da) : m_dbg_rd;
    if (c_rd && ca == 2'd0) n_dn_full = 0;
    if (ds && dw && da == 2'd0) begin n_dn_data = dd; n_dn_full = 1; end
    if (ds && dw && da == 2'd1) n_dn_flags = dd[31:1];
    if (d_rd && da == 2'd2) n_up_full = 0;
    if (cs && cw && ca == 2'd2) begin n_up_data = cd; n_up_full = 1; end
    if (cs && cw && ca == 2'd3) n_up_flags = cd[7:1];
    @(posedge clk);
    @(negedge clk);
    m_tx = ds && dw && da == 2'd0;
    m_rx = d_rd && da == 2'd2;
    m_dn_data = n_dn_data; m_up_data = n_up_data;
    m_dn_flags = n_dn_flags; m_up_flags = n_up_flags;
    m_dn_full = n_dn_full; m_up_full = n_up_full;
    m_cpu_rd = n_cpu_rd; m_dbg_rd = n_dbg_rd;
    check({tag, " cpu_rdata"}, cpu_rdata, m_cpu_rd);
    check({tag, " dbg_rdata"}, dbg_rdata, m_dbg_rd);
    check({tag, " tx_evt"}, {31'h0, tx_evt}, {31'h0, m_tx});
    check({tag, " rx_evt"}, {31'h0, rx_evt}, {31'h0, m_rx});
  endtask

  task automatic cpu_r(string t, logic [1:0] a);
    step(t, 1, 0, a, 0, 0, 0, 0, 0);
  endtask
  task automatic cpu_w(string t, logic [1:0] a, logic [31:0] d);
    step(t, 1, 1, a, d, 0, 0, 0, 0);
  endtask
  task automatic dbg_r(string t, logic [1:0] a);
    step(t, 0, 0, 0, 0, 1, 0, a, 0);
  endtask
  task automatic dbg_w(string t, logic [1:0] a, logic [31:0] d);
    step(t, 0, 0, 0, 0, 1, 1, a, d);
  endtask
  task automatic idle(string t);
    step(t, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1;
    cpu_sel = 0; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0;
    dbg_sel = 0; dbg_wr = 0; dbg_addr = 0; dbg_wdata = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R12: outputs cleared by reset
    check("R12 cpu_rdata", cpu_rdata, 32'h0);
    check("R12 dbg_rdata", dbg_rdata, 32'h0);
    check("R12 events", {30'h0, tx_evt, rx_evt}, 32'h0);
    rst = 0;

    // R12: stored words start at zero
    cpu_r("R12", 2'd0); check("R12 dn data", cpu_rdata, 32'h0);
    dbg_r("R12", 2'd3); check("R12 up ctrl", dbg_rdata, 32'h0);

    // R1 R2 R7: downlink post and pick-up
    dbg_w("R7", 2'd0, 32'hA5A5_0001);
    check("R7 tx pulse", {31'h0, tx_evt}, 32'h1);
    idle("R7"); check("R7 tx single", {31'h0, tx_evt}, 32'h0);
    cpu_r("R2", 2'd1); check("R2 full set", cpu_rdata, 32'h1);
    cpu_w("R1", 2'd0, 32'hDEAD_BEEF);
    cpu_r("R1", 2'd0); check("R1 dn data", cpu_rdata, 32'hA5A5_0001);
    cpu_r("R2", 2'd1); check("R2 full clear", cpu_rdata, 32'h0);
    dbg_r("R2", 2'd1); check("R2 dbg sees empty", dbg_rdata, 32'h0);

    // R3: downlink flags
    dbg_w("R3", 2'd1, 32'hFFFF_FFFF);
    cpu_r("R3", 2'd1); check("R3 flags", cpu_rdata, 32'hFFFF_FFFE);
    cpu_w("R3", 2'd1, 32'h0);
    cpu_r("R3", 2'd1); check("R3 cpu write ignored", cpu_rdata, 32'hFFFF_FFFE);
    dbg_w("R3", 2'd1, 32'h8000_0003);
    cpu_r("R3", 2'd1); check("R3 flags 2", cpu_rdata, 32'h8000_0002);

    // R4 R5 R8: uplink
    cpu_w("R5", 2'd2, 32'h1234_5678);
    dbg_r("R5", 2'd3); check("R5 up full", dbg_rdata, 32'h1);
    dbg_w("R4", 2'd2, 32'h0BAD_0BAD);
    dbg_w("R5", 2'd3, 32'h0);
    dbg_r("R8", 2'd2); check("R4 up data", dbg_rdata, 32'h1234_5678);
    check("R8 rx pulse", {31'h0, rx_evt}, 32'h1);
    idle("R8"); check("R8 rx single", {31'h0, rx_evt}, 32'h0);
    dbg_r("R5", 2'd3); check("R5 up empty", dbg_rdata, 32'h0);
    cpu_r("R8", 2'd2); check("R8 cpu read no pulse", {31'h0, rx_evt}, 32'h0);
    dbg_r("R5", 2'd3); check("R5 cpu read keeps empty", dbg_rdata, 32'h0);

    // R6: uplink flags and reserved bits
    cpu_w("R6", 2'd3, 32'hFFFF_FFFF);
    dbg_r("R6", 2'd3); check("R6 flags", dbg_rdata, 32'h0000_00FE);
    dbg_w("R6", 2'd3, 32'h0);
    cpu_r("R6", 2'd3); check("R6 dbg write ignored", cpu_rdata, 32'h0000_00FE);

    // R9: overwrite while full
    dbg_w("R9", 2'd0, 32'h1111_1111);
    dbg_w("R9", 2'd0, 32'h2222_2222);
    cpu_r("R9", 2'd1); check("R9 still full", cpu_rdata, 32'h8000_0003);
    cpu_r("R9", 2'd0); check("R9 newer word", cpu_rdata, 32'h2222_2222);

    // R10: same-cycle produce and consume
    dbg_w("R10", 2'd0, 32'h3333_3333);
    step("R10", 1, 0, 2'd0, 0, 1, 1, 2'd0, 32'h4444_4444);
    check("R10 reader gets old", cpu_rdata, 32'h3333_3333);
    cpu_r("R10", 2'd1); check("R10 dn stays full", cpu_rdata, 32'h8000_0003);
    step("R10", 1, 1, 2'd2, 32'h5555_5555, 1, 0, 2'd2, 0);
    check("R10 dbg gets old", dbg_rdata, 32'h1234_5678);
    dbg_r("R10", 2'd3); check("R10 up stays full", dbg_rdata, 32'h0000_00FF);

    // R11: read data holds across idle cycles and writes
    repeat (3) idle("R11");
    cpu_w("R11", 2'd3, 32'h0);
    check("R11 hold", dbg_rdata, 32'h0000_00FF);

    // mixed random traffic on both ports
    for (int i = 0; i < 400; i++) begin
      step("R11 random", $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           2'($urandom_range(0, 3)), $urandom,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           2'($urandom_range(0, 3)), $urandom);
    end

    // R12: reset mid-run clears everything
    rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0;
    model_reset();
    cpu_r("R12", 2'd2); check("R12 up data cleared", cpu_rdata, 32'h0);
    dbg_r("R12", 2'd1); check("R12 dn ctrl cleared", dbg_rdata, 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule